// File: doc/BRIEF.md
# Console Keyboard and Display Register Block

This block sits on the data bus of a 16-bit processor and lets software drive a character console through four word registers. Each channel has a status word and a data word. The keyboard channel captures one incoming character code at a time. The display channel passes one outgoing character at a time to the display, using a short handshake.

Software either polls bit 15 of a status word or enables bit 14 so that the channel raises its interrupt request. The ready bits are never written directly. A keyboard character arriving sets the keyboard ready bit, and reading the keyboard data word clears it. Writing the display data word clears the display ready bit, and the display's completion signal sets it again. While the keyboard ready bit is set, new characters are locked out. While the display ready bit is clear, writes to the display data word are dropped.

The bus read data is combinational from the selected register and is zero when no read strobe is active. Side effects of a read or write take place at the clock edge that ends the strobe cycle.

Top module: `console_io_regs`

## Requirements
- R1: The registers decode at keyboard status = base+0, keyboard data = base+2, display status = base+4 and display data = base+6, with base 0xFE00. A read of any other address returns zero and changes no state. In particular, it does not clear the keyboard ready bit.
- R2: A keyboard strobe while the keyboard ready bit is 0 stores the 8-bit code in keyboard data bits [7:0], with bits [15:8] reading zero. It also sets keyboard status bit 15 from the next cycle.
- R3: While the keyboard ready bit is 1, keyboard strobes are ignored and the stored code is unchanged.
- R4: A bus read of the keyboard data word clears the keyboard ready bit at that clock edge, after which the next strobe is accepted.
- R5: A bus write to the display data word while the display ready bit is 1 clears that bit. In the following cycle it drives a one-cycle display valid pulse, with the display character equal to write data bits [7:0].
- R6: A bus write to the display data word while the display ready bit is 0 is ignored: no valid pulse occurs and the display character is unchanged.
- R7: After reset, the display ready bit is 1, and the keyboard ready bit and both enable bits are 0. The display ready bit is set again only on a 0-to-1 transition of the display's ready input.
- R8: In both status words, bit 14 is the interrupt enable, which a bus write to that word sets from write data bit 14. Bit 15 ignores bus writes, and all other bits read zero.
- R9: Each channel's interrupt request is 1 exactly when that channel's ready bit and enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Bus word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not reading |
| key_valid | input | 1 | Keyboard character strobe |
| key_code | input | 8 | Keyboard character code |
| disp_ready | input | 1 | Display ready; a rising edge marks completion |
| disp_valid | output | 1 | One-cycle character pulse to the display |
| disp_char | output | 8 | Character to the display |
| kbd_irq | output | 1 | Keyboard interrupt request |
| dsp_irq | output | 1 | Display interrupt request |

## Verification
A table of distinct key codes is pushed through the arrive, read-status, read-data and read-status-again cycle. This checks that each code lands in the low byte and that only the data read clears the ready bit.

Bursts of two keys without a read separate correct lockout from overwrite. Reads of odd and out-of-range addresses while a key is pending show whether the decode has stray side effects.

On the display side, a write while busy is compared against a write while ready. Holding the ready input high after a write, and comparing that with a low-to-high transition, shows whether completion is detected as an edge or as a level. Enable-bit patterns written with all bits set show whether the read-only and zero bits are protected and whether each request follows its own channel.

// File: rtl/con_io_pkg.sv
// Shared constants for the console register block: register offsets,
// status bit positions and the register select encoding.
// Assumes word registers spaced two bytes apart.
package con_io_pkg;
    localparam int unsigned OFS_KSTAT = 0;
    localparam int unsigned OFS_KDATA = 2;
    localparam int unsigned OFS_DSTAT = 4;
    localparam int unsigned OFS_DDATA = 6;
    localparam int unsigned READY_BIT = 15;
    localparam int unsigned IE_BIT    = 14;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_KSTAT,
        SEL_KDATA,
        SEL_DSTAT,
        SEL_DDATA
    } reg_sel_t;
endpackage

// File: rtl/con_io_decode.sv
// Address decoder: maps a full bus address to one of the four registers.
// Assumes an exact match on all address bits; anything else is SEL_NONE.
module con_io_decode
    import con_io_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFE00
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    localparam logic [ADDR_W-1:0] A_KSTAT = BASE_ADDR + ADDR_W'(OFS_KSTAT);
    localparam logic [ADDR_W-1:0] A_KDATA = BASE_ADDR + ADDR_W'(OFS_KDATA);
    localparam logic [ADDR_W-1:0] A_DSTAT = BASE_ADDR + ADDR_W'(OFS_DSTAT);
    localparam logic [ADDR_W-1:0] A_DDATA = BASE_ADDR + ADDR_W'(OFS_DDATA);

    // Compare the address against each register location.
    always_comb begin
        sel = SEL_NONE;
        if (addr == A_KSTAT)      sel = SEL_KSTAT;
        else if (addr == A_KDATA) sel = SEL_KDATA;
        else if (addr == A_DSTAT) sel = SEL_DSTAT;
        else if (addr == A_DDATA) sel = SEL_DDATA;
    end
endmodule

// File: rtl/con_kbd_chan.sv
// Keyboard channel: holds one character, a ready flag and an interrupt enable.
// Assumes key_valid is a single-cycle strobe; strobes while ready are dropped.
module con_kbd_chan #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_code,
    input  logic              data_rd,
    input  logic              stat_wr,
    input  logic              ie_in,
    output logic              ready,
    output logic              ie,
    output logic [CHAR_W-1:0] code,
    output logic              irq
);
    // Capture characters, clear on data read, update enable on status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
            ie    <= 1'b0;
            code  <= '0;
        end else begin
            if (stat_wr) ie <= ie_in;
            if (ready) begin
                if (data_rd) ready <= 1'b0;
            end else if (key_valid) begin
                ready <= 1'b1;
                code  <= key_code;
            end
        end
    end

    // Request follows ready and enable.
    always_comb irq = ready & ie;

    AST_KEY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && key_valid) |=> (ready && code == $past(key_code))); // R2
    AST_KEY_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> $stable(code)); // R3
    AST_KEY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && data_rd) |=> !ready); // R4
endmodule

// File: rtl/con_dsp_chan.sv
// Display channel: ready flag, interrupt enable and a one-cycle output pulse.
// Assumes the display lowers dev_ready while busy and raises it when done.
module con_dsp_chan #(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [CHAR_W-1:0] wr_char,
    input  logic              stat_wr,
    input  logic              ie_in,
    input  logic              dev_ready,
    output logic              ready,
    output logic              ie,
    output logic              irq,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char
);
    logic dev_prev;

    // Accept writes when ready, pulse the display, re-arm on completion edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready     <= 1'b1;
            ie        <= 1'b0;
            out_valid <= 1'b0;
            out_char  <= '0;
            dev_prev  <= 1'b0;
        end else begin
            dev_prev  <= dev_ready;
            out_valid <= 1'b0;
            if (stat_wr) ie <= ie_in;
            if (ready) begin
                if (data_wr) begin
                    ready     <= 1'b0;
                    out_valid <= 1'b1;
                    out_char  <= wr_char;
                end
            end else if (dev_ready && !dev_prev) begin
                ready <= 1'b1;
            end
        end
    end

    // Request follows ready and enable.
    always_comb irq = ready & ie;

    AST_DSP_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R5
    AST_DSP_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && data_wr) |=> (!out_valid && $stable(out_char))); // R6
endmodule

// File: rtl/console_io_regs.sv
// Console register block: decodes four bus registers and connects them to
// the keyboard and display channels. Read data is combinational and zero
// unless bus_rd is high; side effects occur on the clock edge of the strobe.
module console_io_regs
    import con_io_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CHAR_W = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_code,
    input  logic              disp_ready,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_char,
    output logic              kbd_irq,
    output logic              dsp_irq
);
    reg_sel_t          sel;
    logic              k_ready, k_ie, d_ready, d_ie;
    logic [CHAR_W-1:0] k_code;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata;

    con_io_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr(bus_addr), .sel(sel)
    );

    con_kbd_chan #(.CHAR_W(CHAR_W)) u_kbd (
        .clk(clk), .rst_n(rst_n),
        .key_valid(key_valid), .key_code(key_code),
        .data_rd(bus_rd && sel == SEL_KDATA),
        .stat_wr(bus_wr && sel == SEL_KSTAT),
        .ie_in(bus_wdata[IE_BIT]),
        .ready(k_ready), .ie(k_ie), .code(k_code), .irq(kbd_irq)
    );

    con_dsp_chan #(.CHAR_W(CHAR_W)) u_dsp (
        .clk(clk), .rst_n(rst_n),
        .data_wr(bus_wr && sel == SEL_DDATA),
        .wr_char(bus_wdata[CHAR_W-1:0]),
        .stat_wr(bus_wr && sel == SEL_DSTAT),
        .ie_in(bus_wdata[IE_BIT]),
        .dev_ready(disp_ready),
        .ready(d_ready), .ie(d_ie), .irq(dsp_irq),
        .out_valid(disp_valid), .out_char(disp_char)
    );

    // Read multiplexer over the selected register.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_KSTAT: begin
                    bus_rdata[READY_BIT] = k_ready;
                    bus_rdata[IE_BIT]    = k_ie;
                end
                SEL_KDATA: bus_rdata = DATA_W'(k_code);
                SEL_DSTAT: begin
                    bus_rdata[READY_BIT] = d_ready;
                    bus_rdata[IE_BIT]    = d_ie;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> ($past(bus_wr) && $past(sel) == SEL_DDATA)); // R5
    AST_UNMAPPED_KEEPS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (k_ready && !(bus_rd && sel == SEL_KDATA)) |=> k_ready); // R1
endmodule

// File: tb/sim_console_io_regs.sv
module sim_console_io_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        key_valid = 1'b0;
    logic [7:0]  key_code = '0;
    logic        disp_ready = 1'b1;
    logic        disp_valid;
    logic [7:0]  disp_char;
    logic        kbd_irq, dsp_irq;

    int total = 0, bad = 0, pulses = 0;
    bit done = 0;

    localparam logic [15:0] KST = 16'hFE00, KDT = 16'hFE02, DST = 16'hFE04, DDT = 16'hFE06;
    localparam logic [7:0] CODES [5] = '{8'h41, 8'h00, 8'hFF, 8'h7A, 8'h0D};

    always #5 clk = ~clk;

    console_io_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .key_valid(key_valid), .key_code(key_code), .disp_ready(disp_ready),
        .disp_valid(disp_valid), .disp_char(disp_char),
        .kbd_irq(kbd_irq), .dsp_irq(dsp_irq)
    );

    always @(negedge clk) if (disp_valid) pulses++;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic key(input logic [7:0] c);
        @(negedge clk); key_valid = 1'b1; key_code = c;
        @(negedge clk); key_valid = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7 reset state
        rd(KST, d); chk("R7 kstat reset", d, 16'h0000);
        rd(DST, d); chk("R7 dstat reset", d, 16'h8000);
        chk("R9 irqs reset", {14'b0, kbd_irq, dsp_irq}, 16'h0);
        chk("R7 no pulse at reset", {15'b0, disp_valid}, 16'h0);
        // R2 R4 table walk
        foreach (CODES[i]) begin
            key(CODES[i]);
            rd(KST, d); chk("R2 ready set", d, 16'h8000);
            rd(KDT, d); chk("R2 code low byte", d, {8'h00, CODES[i]});
            rd(KST, d); chk("R4 ready cleared", d, 16'h0000);
        end
        // R3 lockout
        key(8'h31); key(8'h32);
        rd(KDT, d); chk("R3 second key ignored", d, 16'h0031);
        key(8'h33);
        rd(KDT, d); chk("R4 key after read", d, 16'h0033);
        // R1 unmapped reads with a key pending
        key(8'h44);
        rd(16'hFE01, d); chk("R1 odd addr zero", d, 16'h0);
        rd(16'hFE08, d); chk("R1 out of range zero", d, 16'h0);
        rd(16'h0002, d); chk("R1 far addr zero", d, 16'h0);
        rd(KST, d); chk("R1 no side effect", d, 16'h8000);
        rd(KDT, d); chk("R1 data intact", d, 16'h0044);
        // R8 R9 enable handling
        wr(KST, 16'hFFFF);
        rd(KST, d); chk("R8 only bit14 written", d, 16'h4000);
        chk("R9 kbd irq needs ready", {15'b0, kbd_irq}, 16'h0);
        key(8'h55);
        chk("R9 kbd irq raised", {15'b0, kbd_irq}, 16'h1);
        chk("R9 dsp irq stays low", {15'b0, dsp_irq}, 16'h0);
        rd(KDT, d);
        chk("R9 kbd irq drops", {15'b0, kbd_irq}, 16'h0);
        wr(DST, 16'h3FFF);
        rd(DST, d); chk("R8 bit14 zero write", d, 16'h8000);
        wr(DST, 16'h4000);
        rd(DST, d); chk("R8 dstat enable", d, 16'hC000);
        chk("R9 dsp irq raised", {15'b0, dsp_irq}, 16'h1);
        // R5 accepted write
        p0 = pulses;
        wr(DDT, 16'hAB41);
        chk("R5 valid pulse", {15'b0, disp_valid}, 16'h1);
        chk("R5 char", {8'h0, disp_char}, 16'h0041);
        @(negedge clk);
        chk("R5 pulse one cycle", {15'b0, disp_valid}, 16'h0);
        rd(DST, d); chk("R5 ready cleared", d, 16'h4000);
        chk("R9 dsp irq drops", {15'b0, dsp_irq}, 16'h0);
        // R6 dropped write while busy; R7 level high is not completion
        wr(DDT, 16'h0055);
        repeat (2) @(negedge clk);
        chk("R6 no extra pulse", 16'(pulses - p0), 16'h1);
        chk("R6 char unchanged", {8'h0, disp_char}, 16'h0041);
        rd(DST, d); chk("R7 level not edge", d, 16'h4000);
        // R7 completion edge
        disp_ready = 1'b0;
        @(negedge clk); disp_ready = 1'b1;
        @(negedge clk);
        rd(DST, d); chk("R7 ready on rise", d, 16'hC000);
        wr(DDT, 16'h0062);
        chk("R5 second char", {8'h0, disp_char}, 16'h0062);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule